// File: doc/BRIEF.md
# Pseudo-Random Link Self-Test Checker

This block sits behind a link receiver's character decoder and checks the received character stream against a locally generated pseudo-random sequence while the link runs its self-test. Each decoded character is 9 bits wide. Bit 8 is the command flag, which is 1 for a command character and 0 for a data character. Bits 7:0 carry the data. A 9-bit maximal-length LFSR gives a repeating pattern of 511 characters.

The checker starts in a hunting state. It waits for the loop start code, which is the data character 00 hex (all 9 bits zero) and is sent once per loop. After it sees that code it switches to checking. In checking it compares every later character with its own sequence and flags each character that differs. It also gives a one-cycle pulse each time a full pass of the sequence completes. If errors pile up within one loop, it gives up, rewinds its LFSR and hunts again. Code-violation and disparity flags from the decoder play no part in the test.

Characters arrive on a valid/ready input. The checker consumes one character on every clock edge where `in_valid` is high. It never applies back-pressure, so `in_ready` is always high. The output pulses are plain registered control signals, one cycle after the character that caused them.

Top module: `lfsr_link_checker`

## Requirements
- R1: After reset, `checking_o`, `mismatch_o` and `loop_o` are all 0 and the block is hunting.
- R2: While hunting, only an accepted character equal to 9'h000 (flag bit 8 = 0, data 00) moves the block to checking, visible on `checking_o` one cycle later. Any other character, including 9'h100, leaves it hunting and raises no `mismatch_o`.
- R3: Let S0 = 9'h1FF and S(k+1) = {S(k)[7:0], S(k)[8] ^ S(k)[4]}, which is the polynomial x^9+x^5+1. The start code is position 0. For the character at position k, the expected value is ~S(k). In checking, `mismatch_o` is high for exactly one cycle, the cycle after an accepted character, if and only if that character differs from its expected value.
- R4: `loop_o` pulses for one cycle after the character at position 510, which is the last one before S returns to 9'h1FF. Checking then continues, and the next expected character is 9'h000.
- R5: `in_viol` has no effect on any output.
- R6: A mismatch counter clears at the start code. When the ERR_LIMIT-th mismatch of one loop arrives, the block reports that mismatch, gives no loop pulse for it, and returns to hunting with the sequence rewound.
- R7: The mismatch counter also clears at each loop boundary, so mismatches spread over loops never abort as long as each loop holds fewer than ERR_LIMIT.
- R8: While `test_en_n` is high, the block hunts with its sequence rewound, and `mismatch_o` and `loop_o` stay 0 one cycle later.
- R9: Cycles with `in_valid` low change no state and give 0 on `mismatch_o` and `loop_o` one cycle later. `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en_n | input | 1 | Self-test enable, active low |
| in_valid | input | 1 | Character present this cycle |
| in_ready | output | 1 | Always 1, the checker never stalls |
| in_char | input | 9 | Decoded character, bit 8 = command flag |
| in_viol | input | 1 | Decoder violation/disparity flag (ignored) |
| mismatch_o | output | 1 | Registered per-character compare error |
| loop_o | output | 1 | Registered one-cycle pulse per completed loop |
| checking_o | output | 1 | 1 while the start code has been found and comparing is active |

## Verification
The bench builds the checker with ERR_LIMIT = 4, down from the default of 8. With this value, several directed and random corruption patterns complete in a few loops. These include three errors per loop for two loops, which must never abort because the counter clears at each boundary. They also include a four-error burst, which must abort on its fourth error. The LFSR keeps its full 9-bit width, so every run goes through the complete 511-character pass. This lets the bench observe the wrap-around pulse and the return of the 00 start code several times.

// File: rtl/lfsr_chk_pkg.sv
package lfsr_chk_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_CHECK = 1'b1
  } chk_state_e;

endpackage

// File: rtl/lfsr_chk_seq.sv
// Local sequence generator: Fibonacci LFSR whose inverted state is the
// expected character. Rewind loads all ones; sync loads the successor of
// all ones (the position after the start code).
module lfsr_chk_seq #(
  parameter int W   = 9,
  parameter int TAP = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rewind,
  input  logic         sync,
  input  logic         advance,
  output logic [W-1:0] state_o,
  output logic [W-1:0] next_o
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] st_q;
  logic [W-1:0] after_ones;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP-1]};
  endfunction

  assign next_o     = step(st_q);
  assign after_ones = step(ALL_ONES);
  assign state_o    = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ALL_ONES;
    else if (rewind)  st_q <= ALL_ONES;
    else if (sync)    st_q <= after_ones;
    else if (advance) st_q <= next_o;
  end

endmodule

// File: rtl/lfsr_chk_errcnt.sv
// Mismatch counter within one loop; flags when the next hit reaches LIMIT.
module lfsr_chk_errcnt #(
  parameter int LIMIT = 8,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          hit,
  output logic          at_edge,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] EDGE = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign at_edge = (cnt_q == EDGE);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (hit)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/lfsr_link_checker.sv
module lfsr_link_checker
  import lfsr_chk_pkg::*;
#(
  parameter int LFSR_W    = 9,
  parameter int LFSR_TAP  = 5,
  parameter int ERR_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LFSR_W-1:0] in_char,
  input  logic              in_viol,
  output logic              mismatch_o,
  output logic              loop_o,
  output logic              checking_o
);

  localparam int            CNT_W     = $clog2(ERR_LIMIT + 1);
  localparam logic [LFSR_W-1:0] ALL_ONES = '1;
  localparam logic [LFSR_W-1:0] START_CODE = '0;

  chk_state_e        state_q, state_d;
  logic [LFSR_W-1:0] seq_state, seq_next, expected;
  logic [CNT_W-1:0]  err_cnt;
  logic              cnt_edge;
  logic              is_hunt, is_check;
  logic              start_seen, chk_now, differs, abort, wrap;
  logic              mis_q, loop_q;
  logic              unused_viol;

  assign in_ready    = 1'b1;
  assign unused_viol = in_viol;

  assign is_hunt  = (state_q == ST_HUNT);
  assign is_check = (state_q == ST_CHECK);
  assign expected = ~seq_state;
  assign differs  = (in_char != expected);

  assign start_seen = !test_en_n && in_valid && is_hunt && (in_char == START_CODE);
  assign chk_now    = !test_en_n && in_valid && is_check;
  assign abort      = chk_now && differs && cnt_edge;
  assign wrap       = chk_now && !abort && (seq_next == ALL_ONES);

  always_comb begin
    state_d = state_q;
    if (test_en_n)       state_d = ST_HUNT;
    else if (start_seen) state_d = ST_CHECK;
    else if (abort)      state_d = ST_HUNT;
  end

  lfsr_chk_seq #(
    .W   (LFSR_W),
    .TAP (LFSR_TAP)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rewind  (test_en_n || abort),
    .sync    (start_seen),
    .advance (chk_now && !abort),
    .state_o (seq_state),
    .next_o  (seq_next)
  );

  lfsr_chk_errcnt #(
    .LIMIT (ERR_LIMIT),
    .CW    (CNT_W)
  ) i_errcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (test_en_n || abort || start_seen || wrap),
    .hit     (chk_now && differs),
    .at_edge (cnt_edge),
    .cnt_o   (err_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      mis_q   <= 1'b0;
      loop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mis_q   <= chk_now && differs;
      loop_q  <= wrap;
    end
  end

  assign mismatch_o = mis_q;
  assign loop_o     = loop_q;
  assign checking_o = is_check;

endmodule

// File: rtl/lfsr_link_checker_sva.sv
module lfsr_link_checker_sva #(
  parameter int ERR_LIMIT = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_en_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [8:0]       in_char,
  input logic             mismatch_o,
  input logic             loop_o,
  input logic             checking_o,
  input logic [CNT_W-1:0] err_cnt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!mismatch_o && !loop_o)); // R9

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_ready); // R9

  AST_DISABLE_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    test_en_n |=> (!checking_o && !mismatch_o && !loop_o)); // R8

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!checking_o && in_valid) |=> !mismatch_o); // R2

  AST_HUNT_NONSTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!checking_o && in_valid && (in_char != 9'h000)) |=> !checking_o); // R2

  AST_LOOP_KEEPS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    loop_o |-> checking_o); // R4

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(checking_o) |-> (mismatch_o || $past(test_en_n))); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt < CNT_W'(ERR_LIMIT)); // R7

endmodule

bind lfsr_link_checker lfsr_link_checker_sva #(
  .ERR_LIMIT (ERR_LIMIT),
  .CNT_W     (CNT_W)
) i_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .test_en_n  (test_en_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_char    (in_char),
  .mismatch_o (mismatch_o),
  .loop_o     (loop_o),
  .checking_o (checking_o),
  .err_cnt    (err_cnt)
);

// File: tb/test_lfsr_link_checker.sv
`timescale 1ns/1ps
module test_lfsr_link_checker;

  localparam int LIM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_en_n = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_char = '0;
  logic       in_viol = 1'b0;
  logic       mismatch_o, loop_o, checking_o;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic       m_check = 1'b0;
  logic [8:0] m_lfsr  = 9'h1FF;
  int         m_err   = 0;
  logic       e_mis   = 1'b0;
  logic       e_loop  = 1'b0;

  // transmit-side generator
  logic [8:0] tx_lfsr = 9'h1FF;
  int         tx_pos  = 0;

  always #4 clk = ~clk;

  lfsr_link_checker #(.ERR_LIMIT(LIM)) i_lfsr_link_checker (
    .clk(clk), .rst_n(rst_n), .test_en_n(test_en_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_char(in_char), .in_viol(in_viol),
    .mismatch_o(mismatch_o), .loop_o(loop_o), .checking_o(checking_o));

  function automatic logic [8:0] nstep(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [8:0] tx_next_char();
    return ~tx_lfsr;
  endfunction

  task automatic tx_adv();
    tx_lfsr = nstep(tx_lfsr);
    tx_pos  = (tx_pos == 510) ? 0 : tx_pos + 1;
  endtask

  task automatic tx_rewind();
    tx_lfsr = 9'h1FF;
    tx_pos  = 0;
  endtask

  task automatic chk1(input logic act, input logic exp, input string what, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input logic [8:0] c, input logic v);
    logic [8:0] nx;
    e_mis = 1'b0;
    e_loop = 1'b0;
    if (test_en_n) begin
      m_check = 1'b0; m_lfsr = 9'h1FF; m_err = 0;
    end else if (v) begin
      if (!m_check) begin
        if (c == 9'h000) begin
          m_check = 1'b1; m_lfsr = nstep(9'h1FF); m_err = 0;
        end
      end else begin
        e_mis = (c != ~m_lfsr);
        nx = nstep(m_lfsr);
        if (e_mis && (m_err + 1 >= LIM)) begin
          m_check = 1'b0; m_lfsr = 9'h1FF; m_err = 0;
        end else begin
          if (e_mis) m_err++;
          if (nx == 9'h1FF) begin
            e_loop = 1'b1; m_err = 0;
          end
          m_lfsr = nx;
        end
      end
    end
  endtask

  task automatic send(input logic [8:0] c, input logic v, input logic viol, input string tag);
    @(negedge clk);
    in_char = c; in_valid = v; in_viol = viol;
    model(c, v);
    @(negedge clk);
    in_valid = 1'b0;
    chk1(mismatch_o, e_mis, "mismatch_o", tag);
    chk1(loop_o, e_loop, "loop_o", tag);
    chk1(checking_o, m_check, "checking_o", tag);
  endtask

  // send the next transmit character, optionally corrupted
  task automatic send_tx(input logic corrupt, input string tag);
    logic [8:0] c;
    c = tx_next_char();
    if (corrupt) c = c ^ 9'($urandom_range(1, 511));
    send(c, 1'b1, 1'($urandom_range(0, 1)), tag);
    tx_adv();
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk1(checking_o, 1'b0, "checking_o", "R1");
    chk1(mismatch_o, 1'b0, "mismatch_o", "R1");
    chk1(loop_o, 1'b0, "loop_o", "R1");
    rst_n = 1'b1;
    test_en_n = 1'b0;

    // R2: hunting ignores non-start characters, including command 00
    send(9'h100, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 24; i++)
      send(9'($urandom_range(1, 511)), 1'b1, 1'($urandom_range(0, 1)), "R2");

    // R3/R4/R5/R9: two clean loops, random violations and idle garbage
    tx_rewind();
    for (int i = 0; i < 2 * 511 + 1; i++) begin
      if ($urandom_range(0, 7) == 0)
        send(9'($urandom), 1'b0, 1'b1, "R9");
      send_tx(1'b0, "R3_R4_R5");
    end

    // R7: three errors in each of two loops never abort
    for (int i = 0; i < 2 * 511; i++)
      send_tx(tx_pos == 50 || tx_pos == 200 || tx_pos == 509, "R7");

    // R6: burst of LIM errors aborts, then correct data is not compared
    for (int i = 0; i < LIM; i++) send_tx(1'b1, "R6");
    for (int i = 0; i < 30; i++) send_tx(1'b0, "R6");

    // resync and random corruption
    tx_rewind();
    for (int i = 0; i < 3 * 511; i++)
      send_tx($urandom_range(0, 149) == 0, "R3_R6");

    // R8: enable high forces hunting even with corrupt data
    test_en_n = 1'b1;
    for (int i = 0; i < 20; i++) send_tx(1'b1, "R8");
    test_en_n = 1'b0;
    tx_rewind();
    for (int i = 0; i < 600; i++) send_tx(1'b0, "R8_R4");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule